// File: doc/BRIEF.md
# Byte-Addressable Data Space Controller

This block sits between a small 16-bit processor core and its data memory. The core presents byte effective addresses on two independent ports, one for reads and one for writes, and both may be active in the same cycle. Each port also carries a flag that selects byte or word width. The block decodes every address against a fixed map. The low 2 KB (0000h-07FFh) is a register window served over an external strobe bus. The next region (0800h-0DFFh) is 768 words of RAM held inside the block. The gap from 0E00h to 7FFFh is not implemented. The upper half (8000h-FFFFh) is a window into program space, served by an external fetch unit.

Storage is organised as 16-bit words. The even byte address of a word is its low lane and the odd address is its high lane. On a byte access the block steers the data to or from the lane that address bit 0 selects. Every read returns its result exactly one cycle after the request, whichever region served it. The block also flags addresses in the lowest 8 KB (the near range) on both ports.

Top module: `data_space_ctrl`

## Requirements
- R1: A read in 0000h-07FFh raises sfrRdEn in the same cycle, with sfrRdAddr set to the address with bit 0 cleared. The sfrRdData value present in that cycle is returned on rdData one cycle later. RAM and program-space requests stay low.
- R2: A word written to RAM (0800h-0DFFh) is returned by a later word read of the same word. rdValid and rdData appear exactly one cycle after the rdEn cycle.
- R3: On a byte read, address bit 0 = 0 returns the low lane (bits 7:0) and bit 0 = 1 returns the high lane (bits 15:8). The selected byte is placed in rdData[7:0] and rdData[15:8] is zero.
- R4: A byte write takes its data from wrData[7:0] and changes only the lane selected by wrAddr[0]. The other lane of the word keeps its value.
- R5: A word access ignores address bit 0. A word read or write at an odd address acts on the same word as the even address below it.
- R6: A read from 0E00h-7FFFh returns 0000h and raises no external request. A write there changes no RAM word and raises no sfrWrEn.
- R7: A read with address bit 15 = 1 raises psvReq in the same cycle, with psvAddr equal to address bits 14:0. The psvData value present in that cycle is returned one cycle later. A write with bit 15 = 1 is discarded.
- R8: rdNear is 1 exactly when rdAddr is at most 1FFFh, and wrNear is 1 exactly when wrAddr is at most 1FFFh. Both flags are independent of the enables.
- R9: When a read and a write hit the same RAM word in the same cycle, the read returns the value held before the write.
- R10: A write in 0000h-07FFh raises sfrWrEn, with sfrWrAddr set to the address with bit 0 cleared. sfrWrBe bit 0 enables the low lane and bit 1 the high lane: 11b for a word, 01b for an even byte, 10b for an odd byte. A byte write places wrData[7:0] on both lanes of sfrWrData.
- R11: After reset, rdValid is 0 and rdData is 0000h until the first read completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rdEn | input | 1 | Read request |
| rdAddr | input | 16 | Read byte effective address |
| rdByte | input | 1 | 1 = byte read, 0 = word read |
| rdData | output | 16 | Read result, one cycle after request |
| rdValid | output | 1 | rdData holds a new result |
| rdNear | output | 1 | rdAddr lies in the near range |
| wrEn | input | 1 | Write request |
| wrAddr | input | 16 | Write byte effective address |
| wrByte | input | 1 | 1 = byte write, 0 = word write |
| wrData | input | 16 | Write data (byte writes use bits 7:0) |
| wrNear | output | 1 | wrAddr lies in the near range |
| sfrRdEn | output | 1 | Register-window read strobe |
| sfrRdAddr | output | 16 | Word-aligned register read address |
| sfrRdData | input | 16 | Register read data, valid in the strobe cycle |
| sfrWrEn | output | 1 | Register-window write strobe |
| sfrWrAddr | output | 16 | Word-aligned register write address |
| sfrWrData | output | 16 | Lane-steered register write data |
| sfrWrBe | output | 2 | Register write lane enables |
| psvReq | output | 1 | Program-space window read request |
| psvAddr | output | 15 | Window offset (address bits 14:0) |
| psvData | input | 16 | Program-space data, valid in the request cycle |

## Verification
The bench builds the block with its default map: a 2 KB register window, 768 RAM words starting at 0800h, and a near limit of 1FFFh. With these values the last RAM word at 0DFEh and the first gap address at 0E00h can both be reached in a few cycles. So can the near boundary at 1FFFh/2000h and both ends of the program-space window. Lane steering, same-word read/write collisions and the register strobes are all driven on the same small set of words. Expected results flow through a queue that is compared against every rdValid.

// File: rtl/dspace_pkg.sv
package dspace_pkg;

  typedef enum logic [1:0] {
    SRC_SFR  = 2'd0,
    SRC_RAM  = 2'd1,
    SRC_NONE = 2'd2,
    SRC_PSV  = 2'd3
  } srcSel_t;

  typedef struct packed {
    logic       rdFire;
    srcSel_t    rdSrc;
    logic       rdByte;
    logic       rdHiLane;
    logic       ramWr;
    logic [1:0] ramWrBe;
  } strobes_t;

endpackage

// File: rtl/dspace_ctrl.sv
module dspace_ctrl
  import dspace_pkg::*;
#(
  parameter logic [15:0] SFR_END  = 16'h07FF,
  parameter logic [15:0] RAM_BASE = 16'h0800,
  parameter logic [15:0] RAM_END  = 16'h0DFF,
  parameter logic [15:0] NEAR_END = 16'h1FFF,
  parameter int          IDX_W    = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rdEn,
  input  logic [15:0]      rdAddr,
  input  logic             rdByte,
  input  logic             wrEn,
  input  logic [15:0]      wrAddr,
  input  logic             wrByte,
  input  logic [15:0]      wrData,
  output strobes_t         strb,
  output logic [IDX_W-1:0] rdIdx,
  output logic [IDX_W-1:0] wrIdx,
  output logic [15:0]      wrSteer,
  output logic             sfrRdEn,
  output logic [15:0]      sfrRdAddr,
  output logic             sfrWrEn,
  output logic [15:0]      sfrWrAddr,
  output logic [1:0]       sfrWrBe,
  output logic             psvReq,
  output logic [14:0]      psvAddr,
  output logic             rdNear,
  output logic             wrNear
);

  function automatic srcSel_t regionOf(input logic [15:0] a);
    if (a[15])                            return SRC_PSV;
    else if (a <= SFR_END)                return SRC_SFR;
    else if (a >= RAM_BASE && a <= RAM_END) return SRC_RAM;
    else                                  return SRC_NONE;
  endfunction

  srcSel_t    rdRegion, wrRegion;
  logic [1:0] laneBe;

  always_comb begin
    rdRegion = regionOf(rdAddr);
    wrRegion = regionOf(wrAddr);
    laneBe   = wrByte ? (wrAddr[0] ? 2'b10 : 2'b01) : 2'b11;
    wrSteer  = wrByte ? {wrData[7:0], wrData[7:0]} : wrData;
    rdIdx    = IDX_W'(rdAddr[15:1] - RAM_BASE[15:1]);
    wrIdx    = IDX_W'(wrAddr[15:1] - RAM_BASE[15:1]);

    strb.rdFire   = rdEn;
    strb.rdSrc    = rdRegion;
    strb.rdByte   = rdByte;
    strb.rdHiLane = rdAddr[0];
    strb.ramWr    = wrEn && (wrRegion == SRC_RAM);
    strb.ramWrBe  = laneBe;

    sfrRdEn   = rdEn && (rdRegion == SRC_SFR);
    sfrRdAddr = {rdAddr[15:1], 1'b0};
    sfrWrEn   = wrEn && (wrRegion == SRC_SFR);
    sfrWrAddr = {wrAddr[15:1], 1'b0};
    sfrWrBe   = laneBe;

    psvReq  = rdEn && (rdRegion == SRC_PSV);
    psvAddr = rdAddr[14:0];

    rdNear = (rdAddr <= NEAR_END);
    wrNear = (wrAddr <= NEAR_END);
  end

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({sfrRdEn, psvReq, strb.rdFire && strb.rdSrc == SRC_RAM})); // R1

  AST_PSV_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr[15]) |-> (!sfrWrEn && !strb.ramWr)); // R7

  AST_GAP_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrAddr[15] && wrAddr > RAM_END) |-> (!sfrWrEn && !strb.ramWr)); // R6

  AST_SFR_LANES: assert property (@(posedge clk) disable iff (!rstN)
    sfrWrEn |-> (sfrWrBe != 2'b00)); // R10

  AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (!rstN)
    sfrRdEn |-> !sfrRdAddr[0]); // R5

endmodule

// File: rtl/dspace_datapath.sv
module dspace_datapath
  import dspace_pkg::*;
#(
  parameter int RAM_WORDS = 768,
  parameter int IDX_W     = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobes_t         strb,
  input  logic [IDX_W-1:0] rdIdx,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [15:0]      wrSteer,
  input  logic [15:0]      sfrRdData,
  input  logic [15:0]      psvData,
  output logic [15:0]      rdData,
  output logic             rdValid
);

  localparam int LANES = 2;

  logic [15:0] ram [RAM_WORDS];
  logic [15:0] ramQ;
  logic [15:0] extQ;
  srcSel_t     srcQ;
  logic        byteQ;
  logic        hiQ;
  logic [15:0] wordSel;

  // word array: per-lane write, read-before-write on collision
  always_ff @(posedge clk) begin
    if (strb.ramWr) begin
      for (int ln = 0; ln < LANES; ln++) begin
        if (strb.ramWrBe[ln]) ram[wrIdx][8*ln +: 8] <= wrSteer[8*ln +: 8];
      end
    end
    if (strb.rdFire && strb.rdSrc == SRC_RAM) ramQ <= ram[rdIdx];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      extQ    <= '0;
      srcQ    <= SRC_NONE;
      byteQ   <= 1'b0;
      hiQ     <= 1'b0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strb.rdFire;
      if (strb.rdFire) begin
        extQ  <= (strb.rdSrc == SRC_SFR) ? sfrRdData : psvData;
        srcQ  <= strb.rdSrc;
        byteQ <= strb.rdByte;
        hiQ   <= strb.rdHiLane;
      end
    end
  end

  always_comb begin
    unique case (srcQ)
      SRC_RAM:          wordSel = ramQ;
      SRC_SFR, SRC_PSV: wordSel = extQ;
      default:          wordSel = '0;
    endcase
    rdData = byteQ ? {8'h00, (hiQ ? wordSel[15:8] : wordSel[7:0])} : wordSel;
  end

  AST_GAP_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && srcQ == SRC_NONE) |-> (rdData == 16'h0000)); // R6

  AST_BYTE_ZEXT: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && byteQ) |-> (rdData[15:8] == 8'h00)); // R3

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdFire |=> rdValid); // R2

endmodule

// File: rtl/data_space_ctrl.sv
module data_space_ctrl
  import dspace_pkg::*;
#(
  parameter logic [15:0] SFR_END   = 16'h07FF,
  parameter logic [15:0] RAM_BASE  = 16'h0800,
  parameter int          RAM_WORDS = 768,
  parameter logic [15:0] NEAR_END  = 16'h1FFF
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        rdEn,
  input  logic [15:0] rdAddr,
  input  logic        rdByte,
  output logic [15:0] rdData,
  output logic        rdValid,
  output logic        rdNear,
  input  logic        wrEn,
  input  logic [15:0] wrAddr,
  input  logic        wrByte,
  input  logic [15:0] wrData,
  output logic        wrNear,
  output logic        sfrRdEn,
  output logic [15:0] sfrRdAddr,
  input  logic [15:0] sfrRdData,
  output logic        sfrWrEn,
  output logic [15:0] sfrWrAddr,
  output logic [15:0] sfrWrData,
  output logic [1:0]  sfrWrBe,
  output logic        psvReq,
  output logic [14:0] psvAddr,
  input  logic [15:0] psvData
);

  localparam logic [15:0] RAM_END = 16'(RAM_BASE + 16'(2 * RAM_WORDS) - 16'd1);
  localparam int          IDX_W   = $clog2(RAM_WORDS);

  strobes_t         strb;
  logic [IDX_W-1:0] rdIdx, wrIdx;
  logic [15:0]      wrSteer;

  dspace_ctrl #(
    .SFR_END (SFR_END),
    .RAM_BASE(RAM_BASE),
    .RAM_END (RAM_END),
    .NEAR_END(NEAR_END),
    .IDX_W   (IDX_W)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .rdEn     (rdEn),
    .rdAddr   (rdAddr),
    .rdByte   (rdByte),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrByte   (wrByte),
    .wrData   (wrData),
    .strb     (strb),
    .rdIdx    (rdIdx),
    .wrIdx    (wrIdx),
    .wrSteer  (wrSteer),
    .sfrRdEn  (sfrRdEn),
    .sfrRdAddr(sfrRdAddr),
    .sfrWrEn  (sfrWrEn),
    .sfrWrAddr(sfrWrAddr),
    .sfrWrBe  (sfrWrBe),
    .psvReq   (psvReq),
    .psvAddr  (psvAddr),
    .rdNear   (rdNear),
    .wrNear   (wrNear)
  );

  assign sfrWrData = wrSteer;

  dspace_datapath #(
    .RAM_WORDS(RAM_WORDS),
    .IDX_W    (IDX_W)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .rdIdx    (rdIdx),
    .wrIdx    (wrIdx),
    .wrSteer  (wrSteer),
    .sfrRdData(sfrRdData),
    .psvData  (psvData),
    .rdData   (rdData),
    .rdValid  (rdValid)
  );

endmodule

// File: tb/data_space_ctrl_tb_top.sv
`timescale 1ns/1ps
module data_space_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        rdEn = 1'b0, rdByte = 1'b0, wrEn = 1'b0, wrByte = 1'b0;
  logic [15:0] rdAddr = '0, wrAddr = '0, wrData = '0, extIn = '0;
  logic [15:0] rdData, sfrRdAddr, sfrWrAddr, sfrWrData;
  logic        rdValid, rdNear, wrNear, sfrRdEn, sfrWrEn, psvReq;
  logic [1:0]  sfrWrBe;
  logic [14:0] psvAddr;

  int nChecks = 0;
  int nFail   = 0;
  bit finished = 1'b0;

  logic [15:0] expQ[$];
  string       tagQ[$];

  always #10 clk = ~clk;

  data_space_ctrl dut_i (
    .clk(clk), .rstN(rstN),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdByte(rdByte), .rdData(rdData),
    .rdValid(rdValid), .rdNear(rdNear),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrByte(wrByte), .wrData(wrData), .wrNear(wrNear),
    .sfrRdEn(sfrRdEn), .sfrRdAddr(sfrRdAddr), .sfrRdData(extIn),
    .sfrWrEn(sfrWrEn), .sfrWrAddr(sfrWrAddr), .sfrWrData(sfrWrData), .sfrWrBe(sfrWrBe),
    .psvReq(psvReq), .psvAddr(psvAddr), .psvData(extIn)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: present a read and push its expected result
  task automatic rd(input logic [15:0] a, input logic b, input logic [15:0] ext,
                    input logic [15:0] exp, input string tag);
    rdEn = 1'b1; rdAddr = a; rdByte = b; extIn = ext;
    expQ.push_back(exp);
    tagQ.push_back(tag);
  endtask

  task automatic wr(input logic [15:0] a, input logic b, input logic [15:0] d);
    wrEn = 1'b1; wrAddr = a; wrByte = b; wrData = d;
  endtask

  task automatic step();
    @(negedge clk);
    rdEn = 1'b0; wrEn = 1'b0; rdByte = 1'b0; wrByte = 1'b0;
  endtask

  // monitor: compare each result against the queue head
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (rstN === 1'b1) begin
        if (rdValid === 1'b1) begin
          if (expQ.size() == 0) begin
            chk("R2 unexpected rdValid", 16'h0001, 16'h0000);
          end else begin
            automatic logic [15:0] e = expQ.pop_front();
            automatic string       t = tagQ.pop_front();
            chk(t, rdData, e);
          end
        end else if (expQ.size() != 0) begin
          chk("R2 missing rdValid", 16'h0000, 16'h0001);
          void'(expQ.pop_front());
          void'(tagQ.pop_front());
        end
      end
    end
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R11 rdValid after reset", {15'b0, rdValid}, 16'h0000);
    chk("R11 rdData after reset", rdData, 16'h0000);

    // R2: word write / read, including the last RAM word
    wr(16'h0800, 1'b0, 16'hA1B2); step();
    wr(16'h0DFE, 1'b0, 16'h1234); step();
    rd(16'h0800, 1'b0, 16'h0000, 16'hA1B2, "R2 word 0800"); step();
    rd(16'h0DFE, 1'b0, 16'h0000, 16'h1234, "R2 word 0DFE"); step();

    // R3: byte lanes, zero-extended
    rd(16'h0801, 1'b1, 16'h0000, 16'h00A1, "R3 odd lane"); step();
    rd(16'h0800, 1'b1, 16'h0000, 16'h00B2, "R3 even lane"); step();

    // R4: byte writes touch one lane only
    wr(16'h0802, 1'b0, 16'h1111); step();
    wr(16'h0803, 1'b1, 16'hFF5A); step();
    rd(16'h0802, 1'b0, 16'h0000, 16'h5A11, "R4 high lane write"); step();
    wr(16'h0802, 1'b1, 16'h3377); step();
    rd(16'h0802, 1'b0, 16'h0000, 16'h5A77, "R4 low lane write"); step();

    // R5: word access ignores bit 0
    rd(16'h0DFF, 1'b0, 16'h0000, 16'h1234, "R5 odd word read"); step();
    wr(16'h0805, 1'b0, 16'hBEEF); step();
    rd(16'h0804, 1'b0, 16'h0000, 16'hBEEF, "R5 odd word write"); step();

    // R6: unimplemented gap
    wr(16'h0E00, 1'b0, 16'hDEAD);
    #2 chk("R6 gap write no sfrWrEn", {15'b0, sfrWrEn}, 16'h0000);
    step();
    rd(16'h0E00, 1'b0, 16'h5555, 16'h0000, "R6 gap read 0E00");
    #2 chk("R6 gap read no request", {14'b0, sfrRdEn, psvReq}, 16'h0000);
    step();
    rd(16'h7FFE, 1'b0, 16'h5555, 16'h0000, "R6 gap read 7FFE"); step();
    rd(16'h0DFE, 1'b0, 16'h0000, 16'h1234, "R6 RAM intact after gap write"); step();

    // R7: program-space window
    rd(16'h8005, 1'b1, 16'hC3D4, 16'h00C3, "R7 window byte read");
    #2 chk("R7 psvReq", {15'b0, psvReq}, 16'h0001);
    chk("R7 psvAddr", {1'b0, psvAddr}, 16'h0005);
    step();
    rd(16'hFFFE, 1'b0, 16'h9876, 16'h9876, "R7 window word read");
    #2 chk("R7 psvAddr top", {1'b0, psvAddr}, 16'h7FFE);
    step();
    wr(16'h8000, 1'b0, 16'hAAAA);
    #2 chk("R7 window write discarded", {15'b0, sfrWrEn}, 16'h0000);
    step();

    // R8: near flags
    rdAddr = 16'h1FFF; wrAddr = 16'h0000;
    #2 chk("R8 rdNear 1FFF", {15'b0, rdNear}, 16'h0001);
    chk("R8 wrNear 0000", {15'b0, wrNear}, 16'h0001);
    rdAddr = 16'h2000; wrAddr = 16'h8000;
    #2 chk("R8 rdNear 2000", {15'b0, rdNear}, 16'h0000);
    chk("R8 wrNear 8000", {15'b0, wrNear}, 16'h0000);
    step();

    // R9: same-word read and write in one cycle
    wr(16'h0900, 1'b0, 16'h1111); step();
    rd(16'h0900, 1'b0, 16'h0000, 16'h1111, "R9 read old data");
    wr(16'h0900, 1'b0, 16'h2222); step();
    rd(16'h0900, 1'b0, 16'h0000, 16'h2222, "R9 new data after"); step();

    // R1: register window reads
    rd(16'h0123, 1'b0, 16'h4455, 16'h4455, "R1 sfr word read");
    #2 chk("R1 sfrRdEn", {15'b0, sfrRdEn}, 16'h0001);
    chk("R1 sfrRdAddr", sfrRdAddr, 16'h0122);
    step();
    rd(16'h0101, 1'b1, 16'hABCD, 16'h00AB, "R1 sfr byte read"); step();

    // R10: register window writes
    wr(16'h0201, 1'b1, 16'h0066);
    #2 chk("R10 sfrWrEn", {15'b0, sfrWrEn}, 16'h0001);
    chk("R10 sfrWrAddr", sfrWrAddr, 16'h0200);
    chk("R10 byte lanes", {14'b0, sfrWrBe}, 16'h0002);
    chk("R10 byte data", {8'h00, sfrWrData[15:8]}, 16'h0066);
    step();
    wr(16'h0300, 1'b0, 16'hCAFE);
    #2 chk("R10 word lanes", {14'b0, sfrWrBe}, 16'h0003);
    chk("R10 word data", sfrWrData, 16'hCAFE);
    step();

    repeat (3) step();
    chk("R2 queue drained", 16'(expQ.size()), 16'h0000);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule